// File: doc/BRIEF.md
# LDPC Variable-Node Processing Element

This block is one physical variable (bit) node of a message-passing LDPC decoder attached to an on-chip network. Check-to-bit messages arrive as 48-bit packets. Each packet names one of 64 virtual bit nodes, so a single physical unit serves many code bits in turn. A steering stage keeps, for every virtual node, a running two's-complement sum of its incoming messages and a copy of each message. Once the number of messages announced in the packet header has arrived, the execution unit adds the stored channel LLR. It then sends one extrinsic message per edge back into the network.

Every packet carries two 16-bit words from two independent code blocks, and both are processed side by side. While the execution unit is emitting, the input handshake holds the network port back, so no packet is dropped. Channel LLRs and the per-node destination base address sit in a small configuration store with a plain write port. What fills that store, and the decision to stop iterating, belong to the surrounding decoder.

Top module: `bn_pe`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, and every virtual node has no stored messages.
- R2: The packet layout is: bits [47:43] physical address, [42:37] virtual node id, [36:33] count field, [32] reserved bit, [31:16] word of block A, [15:0] word of block B. A word is sign-magnitude: bit 15 is the sign and bits 14:0 are the magnitude. A packet whose address differs from `NODE_ADDR` is consumed (`in_ready` stays 1) and changes no state.
- R3: The count field gives the number of messages expected, and 0 is treated as 1. No output is produced for a virtual node until that many messages have been accepted for it.
- R4: Messages for different virtual node ids are summed and counted separately, even when their packets are interleaved.
- R5: For edge k, the output word is LLR + sum of all stored messages − message k, computed separately per block. A negative-zero input counts as 0, and a zero result is sent as positive zero (0x0000).
- R6: Results above +32767 or below −32767 saturate to 0x7FFF or 0xFFFF respectively.
- R7: After the accept cycle of the completing packet, one packet per edge appears on consecutive cycles, with the first one a cycle later, in arrival order. Edge k carries address (configured base + k) mod 32, the same virtual id, count field k, and the reserved bit of the completing packet.
- R8: `in_ready` is 0 from the cycle after the completing accept up to and including the cycle in which the second-to-last output packet is shown. A packet held on the input meanwhile is accepted once `in_ready` returns.
- R9: After its last output packet, a virtual node's sum and count return to zero, so the next round starts empty.
- R10: A configuration write sets the LLR pair and the destination base for one virtual node, and emissions that start afterwards use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Unit can take a packet |
| in_pkt | input | 48 | Incoming packet |
| out_valid | output | 1 | Output packet valid for one cycle |
| out_pkt | output | 48 | Outgoing extrinsic packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_vid | input | 6 | Virtual node written |
| cfg_dest | input | 5 | Destination base address |
| cfg_llr_a | input | 16 | Channel LLR, block A (sign-magnitude) |
| cfg_llr_b | input | 16 | Channel LLR, block B (sign-magnitude) |

## Verification
Inputs change on falling edges, and each packet is taken at the next rising edge at which `in_ready` is high. A non-completing accept is followed by a check at the next falling edge that `out_valid` is still 0. The first output packet of a completed node is due one rising edge after the completing accept, since the execution unit registers its output. Edge k follows k cycles later, so the bench compares edge k at the k-th falling edge after that and checks `in_ready` at the same sample. For held packets, the bench checks that `in_ready` is low right after the completing accept and high again in the cycle that shows the last output packet.

// File: rtl/bn_pe_pkg.sv
package bn_pe_pkg;
    localparam int PKT_W   = 48;
    localparam int ADDR_W  = 5;
    localparam int VID_W   = 6;
    localparam int CNT_W   = 4;
    localparam int WORD_W  = 16;
    localparam int MAG_W   = WORD_W - 1;
    localparam int MAX_MAG = (1 << MAG_W) - 1;
    localparam int ACC_W   = WORD_W + CNT_W;
    localparam int TOT_W   = ACC_W + 1;
    localparam int NUM_VID = 1 << VID_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [VID_W-1:0]  vid;
        logic [CNT_W-1:0]  cnt;
        logic              rsv;
        logic [WORD_W-1:0] wa;
        logic [WORD_W-1:0] wb;
    } pkt_t;

    // sign-magnitude word to signed value; negative zero becomes zero
    function automatic logic signed [WORD_W:0] sm_to_tc(input logic [WORD_W-1:0] s);
        logic signed [WORD_W:0] m;
        m = $signed({2'b00, s[MAG_W-1:0]});
        return s[WORD_W-1] ? -m : m;
    endfunction

    // signed sum back to sign-magnitude with symmetric saturation
    function automatic logic [WORD_W-1:0] tc_to_sm_sat(input logic signed [TOT_W-1:0] x);
        logic signed [TOT_W-1:0] lim;
        logic signed [TOT_W-1:0] nx;
        lim = TOT_W'(MAX_MAG);
        nx  = -x;
        if (x > lim)
            return {1'b0, {MAG_W{1'b1}}};
        else if (x < -lim)
            return {1'b1, {MAG_W{1'b1}}};
        else if (x < 0)
            return {1'b1, nx[MAG_W-1:0]};
        else
            return {1'b0, x[MAG_W-1:0]};
    endfunction
endpackage

// File: rtl/bn_cfg_store.sv
module bn_cfg_store
    import bn_pe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [VID_W-1:0]  wr_vid,
    input  logic [ADDR_W-1:0] wr_dest,
    input  logic [WORD_W-1:0] wr_llr_a,
    input  logic [WORD_W-1:0] wr_llr_b,
    input  logic [VID_W-1:0]  rd_vid,
    output logic [ADDR_W-1:0] rd_dest,
    output logic [WORD_W-1:0] rd_llr_a,
    output logic [WORD_W-1:0] rd_llr_b
);
    logic [ADDR_W-1:0] dest_q  [NUM_VID];
    logic [WORD_W-1:0] llra_q  [NUM_VID];
    logic [WORD_W-1:0] llrb_q  [NUM_VID];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VID; v++) begin
                dest_q[v] <= '0;
                llra_q[v] <= '0;
                llrb_q[v] <= '0;
            end
        end else if (we) begin
            dest_q[wr_vid] <= wr_dest;
            llra_q[wr_vid] <= wr_llr_a;
            llrb_q[wr_vid] <= wr_llr_b;
        end
    end

    assign rd_dest  = dest_q[rd_vid];
    assign rd_llr_a = llra_q[rd_vid];
    assign rd_llr_b = llrb_q[rd_vid];
endmodule

// File: rtl/bn_concentrator.sv
module bn_concentrator
    import bn_pe_pkg::*;
#(
    parameter int MAX_EDGES = (1 << CNT_W) - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     fire,
    input  logic [VID_W-1:0]         wr_vid,
    input  logic [CNT_W-1:0]         wr_cnt,
    input  logic [WORD_W-1:0]        wr_a,
    input  logic [WORD_W-1:0]        wr_b,
    output logic                     complete,
    output logic [CNT_W-1:0]         n_edges,
    input  logic                     clr,
    input  logic [VID_W-1:0]         rd_vid,
    input  logic [CNT_W-1:0]         rd_k,
    output logic signed [ACC_W-1:0]  rd_acc_a,
    output logic signed [ACC_W-1:0]  rd_acc_b,
    output logic [WORD_W-1:0]        rd_msg_a,
    output logic [WORD_W-1:0]        rd_msg_b
);
    localparam logic [CNT_W-1:0] LIM_MAX = CNT_W'(MAX_EDGES);

    typedef struct packed {
        logic signed [ACC_W-1:0] acc_a;
        logic signed [ACC_W-1:0] acc_b;
        logic [CNT_W-1:0]        cnt;
    } slot_t;

    logic [CNT_W-1:0]        cnt_q   [NUM_VID];
    logic signed [ACC_W-1:0] acca_q  [NUM_VID];
    logic signed [ACC_W-1:0] accb_q  [NUM_VID];
    logic [WORD_W-1:0]       msga_q  [NUM_VID][MAX_EDGES];
    logic [WORD_W-1:0]       msgb_q  [NUM_VID][MAX_EDGES];

    logic [CNT_W-1:0] limit;
    slot_t            slot_d;

    always_comb begin
        if (wr_cnt == '0)
            limit = CNT_W'(1);
        else if (wr_cnt > LIM_MAX)
            limit = LIM_MAX;
        else
            limit = wr_cnt;
        slot_d.acc_a = acca_q[wr_vid] + ACC_W'(sm_to_tc(wr_a));
        slot_d.acc_b = accb_q[wr_vid] + ACC_W'(sm_to_tc(wr_b));
        slot_d.cnt   = cnt_q[wr_vid] + CNT_W'(1);
    end

    assign complete = fire && (slot_d.cnt >= limit);
    assign n_edges  = slot_d.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int v = 0; v < NUM_VID; v++) begin
                cnt_q[v]  <= '0;
                acca_q[v] <= '0;
                accb_q[v] <= '0;
            end
        end else if (fire) begin
            msga_q[wr_vid][cnt_q[wr_vid]] <= wr_a;
            msgb_q[wr_vid][cnt_q[wr_vid]] <= wr_b;
            acca_q[wr_vid] <= slot_d.acc_a;
            accb_q[wr_vid] <= slot_d.acc_b;
            cnt_q[wr_vid]  <= slot_d.cnt;
        end else if (clr) begin
            cnt_q[rd_vid]  <= '0;
            acca_q[rd_vid] <= '0;
            accb_q[rd_vid] <= '0;
        end
    end

    assign rd_acc_a = acca_q[rd_vid];
    assign rd_acc_b = accb_q[rd_vid];
    assign rd_msg_a = msga_q[rd_vid][rd_k];
    assign rd_msg_b = msgb_q[rd_vid][rd_k];

    // R3: a stored count never reaches the edge capacity before an accept
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (cnt_q[wr_vid] < LIM_MAX));
    // R9: the emitting node is empty in the cycle after its clear
    p_clear_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q[$past(rd_vid)] == '0));
    // R8: accepts and clears never coincide
    p_fire_clr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(fire && clr));
endmodule

// File: rtl/bn_exec_unit.sv
module bn_exec_unit
    import bn_pe_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [VID_W-1:0]         start_vid,
    input  logic [CNT_W-1:0]         start_n,
    input  logic                     start_rsv,
    input  logic signed [ACC_W-1:0]  acc_a,
    input  logic signed [ACC_W-1:0]  acc_b,
    input  logic [WORD_W-1:0]        msg_a,
    input  logic [WORD_W-1:0]        msg_b,
    input  logic [WORD_W-1:0]        llr_a,
    input  logic [WORD_W-1:0]        llr_b,
    input  logic [ADDR_W-1:0]        dest_base,
    output logic                     busy,
    output logic [VID_W-1:0]         rd_vid,
    output logic [CNT_W-1:0]         rd_k,
    output logic                     clr,
    output logic                     out_valid,
    output logic [PKT_W-1:0]         out_pkt
);
    typedef struct packed {
        logic             busy;
        logic [VID_W-1:0] vid;
        logic [CNT_W-1:0] k;
        logic [CNT_W-1:0] n;
        logic             rsv;
        logic             ov;
        pkt_t             pkt;
    } st_t;

    st_t st_q, st_d;
    logic signed [TOT_W-1:0] tot_a, tot_b, ext_a, ext_b;

    always_comb begin
        st_d  = st_q;
        st_d.ov = 1'b0;
        clr   = 1'b0;
        tot_a = TOT_W'(acc_a) + TOT_W'(sm_to_tc(llr_a));
        tot_b = TOT_W'(acc_b) + TOT_W'(sm_to_tc(llr_b));
        ext_a = tot_a - TOT_W'(sm_to_tc(msg_a));
        ext_b = tot_b - TOT_W'(sm_to_tc(msg_b));
        if (st_q.busy) begin
            st_d.ov       = 1'b1;
            st_d.pkt.addr = dest_base + ADDR_W'(st_q.k);
            st_d.pkt.vid  = st_q.vid;
            st_d.pkt.cnt  = st_q.k;
            st_d.pkt.rsv  = st_q.rsv;
            st_d.pkt.wa   = tc_to_sm_sat(ext_a);
            st_d.pkt.wb   = tc_to_sm_sat(ext_b);
            st_d.k        = st_q.k + CNT_W'(1);
            if (st_q.k == st_q.n - CNT_W'(1)) begin
                st_d.busy = 1'b0;
                clr       = 1'b1;
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.vid  = start_vid;
            st_d.n    = start_n;
            st_d.k    = '0;
            st_d.rsv  = start_rsv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign rd_vid    = st_q.vid;
    assign rd_k      = st_q.k;
    assign out_valid = st_q.ov;
    assign out_pkt   = st_q.pkt;

    // R7: the first packet of a burst is edge 0
    p_first_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ov) |-> (st_q.pkt.cnt == '0));
    // R7: output follows one cycle after the unit turns busy
    p_start_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.busy) |=> st_q.ov);
    // R7: a burst keeps one virtual id
    p_vid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ov && $past(st_q.ov)) |-> (st_q.pkt.vid == $past(st_q.pkt.vid)));
    // R5: negative zero never leaves the unit
    p_no_neg_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ov |-> (st_q.pkt.wa != 16'h8000 && st_q.pkt.wb != 16'h8000));
endmodule

// File: rtl/bn_pe.sv
module bn_pe
    import bn_pe_pkg::*;
#(
    parameter logic [ADDR_W-1:0] NODE_ADDR = '0,
    parameter int                MAX_EDGES = (1 << CNT_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PKT_W-1:0]  in_pkt,
    output logic              out_valid,
    output logic [PKT_W-1:0]  out_pkt,
    input  logic              cfg_we,
    input  logic [VID_W-1:0]  cfg_vid,
    input  logic [ADDR_W-1:0] cfg_dest,
    input  logic [WORD_W-1:0] cfg_llr_a,
    input  logic [WORD_W-1:0] cfg_llr_b
);
    pkt_t ip;
    logic fire, complete, busy, clr;
    logic [CNT_W-1:0]        n_edges, rd_k;
    logic [VID_W-1:0]        rd_vid;
    logic signed [ACC_W-1:0] acc_a, acc_b;
    logic [WORD_W-1:0]       msg_a, msg_b, llr_a, llr_b;
    logic [ADDR_W-1:0]       dest_base;

    assign ip       = pkt_t'(in_pkt);
    assign in_ready = !busy;
    assign fire     = in_valid && in_ready && (ip.addr == NODE_ADDR);

    bn_cfg_store u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_vid(cfg_vid),
        .wr_dest(cfg_dest), .wr_llr_a(cfg_llr_a), .wr_llr_b(cfg_llr_b),
        .rd_vid(rd_vid), .rd_dest(dest_base), .rd_llr_a(llr_a), .rd_llr_b(llr_b)
    );

    bn_concentrator #(.MAX_EDGES(MAX_EDGES)) u_conc (
        .clk(clk), .rst_n(rst_n), .fire(fire), .wr_vid(ip.vid), .wr_cnt(ip.cnt),
        .wr_a(ip.wa), .wr_b(ip.wb), .complete(complete), .n_edges(n_edges),
        .clr(clr), .rd_vid(rd_vid), .rd_k(rd_k), .rd_acc_a(acc_a), .rd_acc_b(acc_b),
        .rd_msg_a(msg_a), .rd_msg_b(msg_b)
    );

    bn_exec_unit u_exec (
        .clk(clk), .rst_n(rst_n), .start(complete), .start_vid(ip.vid),
        .start_n(n_edges), .start_rsv(ip.rsv), .acc_a(acc_a), .acc_b(acc_b),
        .msg_a(msg_a), .msg_b(msg_b), .llr_a(llr_a), .llr_b(llr_b),
        .dest_base(dest_base), .busy(busy), .rd_vid(rd_vid), .rd_k(rd_k),
        .clr(clr), .out_valid(out_valid), .out_pkt(out_pkt)
    );

    // R8: the port closes only right after a packet was offered
    p_ready_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |-> $past(in_valid));
endmodule

// File: tb/tb_bn_pe.sv
module tb_bn_pe;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_ADDR = 5'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid;
    logic [47:0] in_pkt = '0, out_pkt;
    logic cfg_we = 1'b0;
    logic [5:0] cfg_vid = '0;
    logic [4:0] cfg_dest = '0;
    logic [15:0] cfg_llr_a = '0, cfg_llr_b = '0;

    int checks = 0, errors = 0;
    logic [15:0] qa [64][16];
    logic [15:0] qb [64][16];
    int          nq [64];
    logic [15:0] blla [64];
    logic [15:0] bllb [64];
    logic [4:0]  bdst [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    bn_pe #(.NODE_ADDR(MY_ADDR)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pkt(in_pkt), .out_valid(out_valid), .out_pkt(out_pkt),
        .cfg_we(cfg_we), .cfg_vid(cfg_vid), .cfg_dest(cfg_dest),
        .cfg_llr_a(cfg_llr_a), .cfg_llr_b(cfg_llr_b)
    );

    function automatic int sm2i(input logic [15:0] s);
        return s[15] ? -int'(s[14:0]) : int'(s[14:0]);
    endfunction

    function automatic logic [15:0] i2sm(input int v);
        if (v > 32767) v = 32767;
        if (v < -32767) v = -32767;
        return (v < 0) ? {1'b1, 15'(-v)} : {1'b0, 15'(v)};
    endfunction

    function automatic logic [47:0] mk(input logic [4:0] a, input logic [5:0] v,
                                       input logic [3:0] c, input logic r,
                                       input logic [15:0] wa, input logic [15:0] wb);
        return {a, v, c, r, wa, wb};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int vid, input logic [4:0] d, input logic [15:0] la, input logic [15:0] lb);
        cfg_we = 1'b1; cfg_vid = 6'(vid); cfg_dest = d; cfg_llr_a = la; cfg_llr_b = lb;
        blla[vid] = la; bllb[vid] = lb; bdst[vid] = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [4:0] a, input int vid, input int c, input logic r,
                        input logic [15:0] wa, input logic [15:0] wb);
        in_pkt = mk(a, 6'(vid), 4'(c), r, wa, wb);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push(input int vid, input int c, input logic r,
                        input logic [15:0] wa, input logic [15:0] wb);
        qa[vid][nq[vid]] = wa; qb[vid][nq[vid]] = wb; nq[vid]++;
        send(MY_ADDR, vid, c, r, wa, wb);
    endtask

    task automatic collect(input int vid, input logic r, input string tag);
        int n = nq[vid];
        for (int k = 0; k < n; k++) begin
            int ta = sm2i(blla[vid]);
            int tb = sm2i(bllb[vid]);
            logic [47:0] exp;
            @(negedge clk);
            for (int j = 0; j < n; j++) begin
                ta += sm2i(qa[vid][j]);
                tb += sm2i(qb[vid][j]);
            end
            exp = mk(5'(int'(bdst[vid]) + k), 6'(vid), 4'(k), r,
                     i2sm(ta - sm2i(qa[vid][k])), i2sm(tb - sm2i(qb[vid][k])));
            chk(out_valid === 1'b1 && out_pkt === exp, tag, {15'd0, out_valid, out_pkt}, {16'h0001, exp});
            chk(in_ready === (k == n - 1), "R8 ready during emission", 64'(in_ready), 64'(k == n - 1));
        end
        nq[vid] = 0;
    endtask

    task automatic t_reset();
        chk(in_ready === 1'b1, "R1 ready after reset", 64'(in_ready), 64'd1);
        chk(out_valid === 1'b0, "R1 no output after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_single_zero_count();
        cfg(1, 5'd7, 16'd100, 16'h8032);
        push(1, 0, 1'b0, 16'd20, 16'h801E);
        chk(in_ready === 1'b0, "R8 ready drops after completion", 64'(in_ready), 64'd0);
        collect(1, 1'b0, "R3 zero count acts as one");
    endtask

    task automatic t_degree3();
        cfg(5, 5'd30, 16'd1000, 16'h83E8);
        push(5, 3, 1'b0, 16'd200, 16'h812C);
        chk(out_valid === 1'b0, "R3 no output after one of three", 64'(out_valid), 64'd0);
        push(5, 3, 1'b0, 16'h8032, 16'd75);
        chk(out_valid === 1'b0, "R3 no output after two of three", 64'(out_valid), 64'd0);
        push(5, 3, 1'b1, 16'd400, 16'd0);
        collect(5, 1'b1, "R5 R7 degree-three extrinsic burst");
    endtask

    task automatic t_interleave();
        cfg(7, 5'd1, 16'd10, 16'd20);
        cfg(9, 5'd16, 16'h800A, 16'd0);
        push(7, 2, 1'b0, 16'd111, 16'd222);
        push(9, 2, 1'b0, 16'd333, 16'h8010);
        chk(out_valid === 1'b0, "R4 separate counts per id", 64'(out_valid), 64'd0);
        push(7, 2, 1'b0, 16'h8005, 16'd9);
        collect(7, 1'b0, "R4 id 7 unaffected by id 9");
        push(9, 2, 1'b0, 16'd44, 16'd55);
        collect(9, 1'b0, "R4 id 9 unaffected by id 7");
    endtask

    task automatic t_wrong_addr();
        cfg(12, 5'd2, 16'd77, 16'd88);
        send(5'd4, 12, 1, 1'b0, 16'd500, 16'd600);
        chk(in_ready === 1'b1, "R2 foreign packet consumed", 64'(in_ready), 64'd1);
        @(negedge clk);
        chk(out_valid === 1'b0, "R2 foreign packet produces nothing", 64'(out_valid), 64'd0);
        push(12, 1, 1'b0, 16'd3, 16'd4);
        collect(12, 1'b0, "R2 foreign packet left no state");
    endtask

    task automatic t_saturate();
        cfg(20, 5'd9, 16'd30000, 16'hF530);
        for (int i = 0; i < 3; i++) push(20, 3, 1'b0, 16'd20000, 16'hCE20);
        collect(20, 1'b0, "R6 saturation both signs");
    endtask

    task automatic t_neg_zero();
        cfg(21, 5'd31, 16'h8000, 16'h0000);
        push(21, 2, 1'b0, 16'h8000, 16'd7);
        push(21, 2, 1'b0, 16'd5, 16'h8007);
        collect(21, 1'b0, "R5 negative zero and positive zero result");
    endtask

    task automatic t_reuse();
        push(5, 2, 1'b0, 16'd1, 16'd2);
        chk(out_valid === 1'b0, "R9 count restarted at zero", 64'(out_valid), 64'd0);
        push(5, 2, 1'b0, 16'd4, 16'h8003);
        collect(5, 1'b0, "R9 sum restarted at zero");
    endtask

    task automatic t_new_cfg();
        cfg(5, 5'd12, 16'h8100, 16'd900);
        push(5, 1, 1'b0, 16'd6, 16'd6);
        collect(5, 1'b0, "R10 new llr and destination used");
    endtask

    task automatic t_stall();
        cfg(30, 5'd4, 16'd50, 16'd60);
        cfg(31, 5'd5, 16'd70, 16'd80);
        push(30, 1, 1'b0, 16'd10, 16'd10);
        qa[31][0] = 16'd12; qb[31][0] = 16'd13; nq[31] = 1;
        in_pkt = mk(MY_ADDR, 6'd31, 4'd1, 1'b0, 16'd12, 16'd13);
        in_valid = 1'b1;
        chk(in_ready === 1'b0, "R8 held packet sees ready low", 64'(in_ready), 64'd0);
        collect(30, 1'b0, "R8 first node emitted while input held");
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b0, "R8 gap before held packet result", 64'(out_valid), 64'd0);
        collect(31, 1'b0, "R8 held packet accepted once ready");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int v = 0; v < 64; v++) begin
            nq[v] = 0; blla[v] = '0; bllb[v] = '0; bdst[v] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_zero_count();
        t_degree3();
        t_interleave();
        t_wrong_addr();
        t_saturate();
        t_neg_zero();
        t_reuse();
        t_new_cfg();
        t_stall();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule